// File: doc/BRIEF.md
# Clock Reference Mode Controller

This block is the supervisory state machine of a telecom synchronisation clock. It decides, cycle by cycle, whether the clock runs free on its local oscillator, is picking an input reference, is locking and tracking a reference, or is holding over on stored history. The loop filter, phase detector and oscillator steering sit outside. Lock progress comes in as single-cycle strobes, one for frequency acquired, one for phase acquired and one for each step down in tracking bandwidth.

The operator's wish is a 3-bit mode request. It comes either from three control pins or, when the register-select input is high, from a 4-bit register field. Six per-reference validity flags, a small table of 4-bit reference priorities, an automatic-switching enable and a revertive enable decide which reference is actually used. Holdover is only allowed while the history is usable. A history-clear strobe withdraws that permission until the external history-valid flag has dropped and come back.

The outputs are the top-level state, the index of the reference in use, a 4-bit locking sub-state code and indicator lines for holdover, free-run, unlock and per-reference lock.

Top module: `clkref_mode_ctrl`

## Requirements
- R1: The pin code decodes as 000 free-run, 001 reference 1, 010 reference 2, 011 holdover, 100 reference 3, 101 reference 4, 110 reference 5, 111 reference 6. `state_o` encodes 0 free-run, 1 reference switching, 2 locking, 3 holdover. `ref_o` carries the reference number 1..6, or 0 for none. After reset the block is in free-run with `ref_o`=0 and `sub_o`=1001.
- R2: While `reg_sel`=1 the pins are ignored and `reg_code` is used. When its bit 3 is 0, its bits 2..0 decode as in R1. When bit 3 is 1, the code is ignored and the previous request stays in force.
- R3: A free-run request moves any state to free-run at the next clock edge. Any change of the request while in free-run, other than to holdover, moves to reference switching at the next edge.
- R4: Free-run moves to holdover only on a change of the request to holdover while history is usable; a request made without usable history is not retried later. Holdover falls back to free-run one edge after the history becomes unusable.
- R5: Reference switching lasts exactly one cycle. If the requested reference is available (valid and priority not 0000), the block enters locking on that reference at the next edge.
- R6: With automatic switching on, an unavailable requested reference is replaced by the available reference with the highest priority. Ties go to the lower-numbered reference. Priority 0000 excludes a reference. If nothing is available, the block goes to holdover, or to free-run when history is unusable.
- R7: With automatic switching off, an unavailable requested reference sends the block from switching to holdover.
- R8: In locking, loss of the reference in use, or a bad-reference strobe, leaves locking at the next edge. The block goes to switching if automatic mode is on and another reference is available; otherwise it goes to holdover.
- R9: With the revertive bit set, a reference lost during locking that becomes available again sends the block from locking back to switching at the next edge, and from there to that reference when it is the requested one. With the revertive bit clear, the block stays on the substitute.
- R10: `sub_o` reads 0001 on entering locking, 0010 after the frequency strobe, 0011 after the phase strobe, and then 0100, 0101, 0110 on successive tracking strobes, saturating at 0110. It reads 0111 in switching entered from locking, 0000 in switching entered otherwise, 1000 in holdover and 1001 in free-run. `ref_o` is 0 in free-run and holdover.
- R11: `ind_ref_lock[n-1]` is high only while locking on reference n with `sub_o` in 0011..0110. `ind_unlock` is the inverse of any lock indication. `ind_holdover` and `ind_freerun` follow the state.
- R12: A `hist_clr` strobe blocks holdover from that cycle on, until `hist_valid` has been seen low and returns high.
- R13: The priorities reset to reference 1..6 = 8,7,6,5,4,3. A write with `prio_we` loads `prio_val` into the priority of reference `prio_sel` (1..6).
- R14: In holdover, when the requested reference becomes available again, the block moves to switching at the next edge and then locks on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_code | input | 3 | Mode request from control pins |
| reg_sel | input | 1 | 1 selects the register code instead of the pins |
| reg_code | input | 4 | Mode request from configuration register |
| auto_en | input | 1 | Automatic priority-based switching enable |
| revert_en | input | 1 | Revertive switching enable |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | 3 | Reference number (1..6) to write |
| prio_val | input | 4 | Priority value to write |
| ref_valid | input | 6 | Per-reference validity, bit n-1 for reference n |
| hist_valid | input | 1 | Holdover history is valid |
| hist_clr | input | 1 | History-clear strobe |
| freq_done | input | 1 | Frequency acquisition complete strobe |
| phase_done | input | 1 | Phase acquisition complete strobe |
| trk_step | input | 1 | Tracking bandwidth step strobe |
| bad_ref | input | 1 | Reference in use judged bad strobe |
| state_o | output | 2 | Top-level state |
| ref_o | output | 3 | Reference in use, 0 for none |
| sub_o | output | 4 | Locking sub-state code |
| ind_holdover | output | 1 | Holdover indicator |
| ind_freerun | output | 1 | Free-run indicator |
| ind_unlock | output | 1 | Not locked indicator |
| ind_ref_lock | output | 6 | Per-reference lock indicator |

## Verification
Every output is registered. A stimulus applied between edges shows up one edge later in `state_o`, `sub_o` and the indicators. A new reference request therefore reads as switching after one edge and as locking on the chosen reference after two. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the following rising edges, counting one edge for each registered step. Strobes are held for exactly one cycle, so each sub-state advance is checked on the edge that consumes it.

// File: rtl/clkref_pkg.sv
package clkref_pkg;
  localparam int N_REF  = 6;
  localparam int PRIO_W = 4;
  localparam int IDX_W  = 3;
  localparam int CODE_W = 3;
  localparam int SUB_W  = 4;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_SWITCH = 2'd1,
    ST_LOCK   = 2'd2,
    ST_HOLD   = 2'd3
  } mode_e;

  localparam logic [SUB_W-1:0] SUB_NONE = 4'd0;
  localparam logic [SUB_W-1:0] SUB_FACQ = 4'd1;
  localparam logic [SUB_W-1:0] SUB_PACQ = 4'd2;
  localparam logic [SUB_W-1:0] SUB_TRK0 = 4'd3;
  localparam logic [SUB_W-1:0] SUB_TRK3 = 4'd6;
  localparam logic [SUB_W-1:0] SUB_PBO  = 4'd7;
  localparam logic [SUB_W-1:0] SUB_HOLD = 4'd8;
  localparam logic [SUB_W-1:0] SUB_FREE = 4'd9;

  localparam logic [CODE_W-1:0] REQ_FREE = 3'b000;
  localparam logic [CODE_W-1:0] REQ_HOLD = 3'b011;

  // Mode request to reference number; 0 when the code names no reference.
  function automatic logic [IDX_W-1:0] code_to_ref(input logic [CODE_W-1:0] c);
    case (c)
      3'b001:  code_to_ref = 3'd1;
      3'b010:  code_to_ref = 3'd2;
      3'b100:  code_to_ref = 3'd3;
      3'b101:  code_to_ref = 3'd4;
      3'b110:  code_to_ref = 3'd5;
      3'b111:  code_to_ref = 3'd6;
      default: code_to_ref = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/clkref_req_decode.sv
module clkref_req_decode #(
  parameter int CODE_W = clkref_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] pin_code,
  input  logic              reg_sel,
  input  logic [CODE_W:0]   reg_code,
  output logic [CODE_W-1:0] req_now,
  output logic              req_chg
);
  logic [CODE_W-1:0] req_q;
  logic              req_ld;

  always_comb begin
    if (reg_sel) begin
      // top bit set marks a code outside the mapping: hold previous request
      req_now = reg_code[CODE_W] ? req_q : reg_code[CODE_W-1:0];
    end else begin
      req_now = pin_code;
    end
  end

  assign req_chg = (req_now != req_q);
  assign req_ld  = req_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_ld) begin
      req_q <= req_now;
    end
  end
endmodule

// File: rtl/clkref_prio_table.sv
module clkref_prio_table #(
  parameter int N_REF  = clkref_pkg::N_REF,
  parameter int PRIO_W = clkref_pkg::PRIO_W,
  parameter int IDX_W  = clkref_pkg::IDX_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_sel,
  input  logic [PRIO_W-1:0]         wr_val,
  output logic [N_REF*PRIO_W-1:0]   prio_flat
);
  for (genvar g = 0; g < N_REF; g++) begin : g_slot
    localparam logic [PRIO_W-1:0] DEF_PRIO = PRIO_W'(N_REF + 2 - g);
    logic [PRIO_W-1:0] prio_q;
    logic              slot_ld;

    assign slot_ld = wr_en && (wr_sel == IDX_W'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q <= DEF_PRIO;
      end else if (slot_ld) begin
        prio_q <= wr_val;
      end
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/clkref_prio_pick.sv
module clkref_prio_pick #(
  parameter int N_REF  = clkref_pkg::N_REF,
  parameter int PRIO_W = clkref_pkg::PRIO_W,
  parameter int IDX_W  = clkref_pkg::IDX_W
) (
  input  logic [N_REF-1:0]        avail,
  input  logic [N_REF*PRIO_W-1:0] prio_flat,
  output logic [IDX_W-1:0]        pick_idx,
  output logic                    pick_any
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower-numbered reference on a tie
  always_comb begin
    best     = '0;
    pick_idx = '0;
    for (int i = 0; i < N_REF; i++) begin
      if (avail[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        best     = prio_flat[i*PRIO_W +: PRIO_W];
        pick_idx = IDX_W'(i + 1);
      end
    end
  end

  assign pick_any = (pick_idx != '0);
endmodule

// File: rtl/clkref_mode_ctrl.sv
module clkref_mode_ctrl
  import clkref_pkg::*;
#(
  parameter int NR = clkref_pkg::N_REF,
  parameter int PW = clkref_pkg::PRIO_W,
  parameter int IW = clkref_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pin_code,
  input  logic              reg_sel,
  input  logic [3:0]        reg_code,
  input  logic              auto_en,
  input  logic              revert_en,
  input  logic              prio_we,
  input  logic [IW-1:0]     prio_sel,
  input  logic [PW-1:0]     prio_val,
  input  logic [NR-1:0]     ref_valid,
  input  logic              hist_valid,
  input  logic              hist_clr,
  input  logic              freq_done,
  input  logic              phase_done,
  input  logic              trk_step,
  input  logic              bad_ref,
  output logic [1:0]        state_o,
  output logic [IW-1:0]     ref_o,
  output logic [3:0]        sub_o,
  output logic              ind_holdover,
  output logic              ind_freerun,
  output logic              ind_unlock,
  output logic [NR-1:0]     ind_ref_lock
);
  function automatic logic bit_at(input logic [NR-1:0] v, input logic [IW-1:0] idx);
    bit_at = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (idx == IW'(i + 1)) bit_at = v[i];
    end
  endfunction

  logic [2:0]       req_now;
  logic             req_chg;
  logic [NR*PW-1:0] prio_flat;
  logic [NR-1:0]    prio_nz, avail, cur_mask;
  logic [IW-1:0]    pick_idx, req_ref;
  logic             pick_any;

  clkref_req_decode #(.CODE_W(3)) u_req (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .reg_sel(reg_sel),
    .reg_code(reg_code), .req_now(req_now), .req_chg(req_chg)
  );

  clkref_prio_table #(.N_REF(NR), .PRIO_W(PW), .IDX_W(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(prio_we), .wr_sel(prio_sel),
    .wr_val(prio_val), .prio_flat(prio_flat)
  );

  for (genvar g = 0; g < NR; g++) begin : g_ref
    assign prio_nz[g]  = |prio_flat[g*PW +: PW];
    assign cur_mask[g] = (ref_o == IW'(g + 1));
  end
  assign avail = ref_valid & prio_nz;

  clkref_prio_pick #(.N_REF(NR), .PRIO_W(PW), .IDX_W(IW)) u_pick (
    .avail(avail), .prio_flat(prio_flat), .pick_idx(pick_idx), .pick_any(pick_any)
  );

  // state registers
  mode_e          st_q, st_d;
  logic [IW-1:0]  ref_q, ref_d, lost_q, lost_d;
  logic [3:0]     sub_q, sub_d;
  logic           hist_blk_q;
  logic           st_ld, ref_ld, lost_ld, sub_ld;

  logic req_free, req_hold, req_avail, cur_avail, any_other, hist_ok, revert_hit;
  mode_e hold_or_free;

  assign req_ref      = code_to_ref(req_now);
  assign req_free     = (req_now == REQ_FREE);
  assign req_hold     = (req_now == REQ_HOLD);
  assign req_avail    = bit_at(avail, req_ref);
  assign cur_avail    = bit_at(avail, ref_q);
  assign any_other    = |(avail & ~cur_mask);
  assign hist_ok      = hist_valid && !hist_blk_q && !hist_clr;
  assign hold_or_free = hist_ok ? ST_HOLD : ST_FREE;
  assign revert_hit   = revert_en && (lost_q != '0) && (lost_q != ref_q) && bit_at(avail, lost_q);

  // next-state process
  always_comb begin
    st_d   = st_q;
    ref_d  = ref_q;
    lost_d = lost_q;
    if (req_free) begin
      st_d = ST_FREE;
    end else begin
      case (st_q)
        ST_FREE: begin
          if (req_chg) begin
            if (!req_hold)    st_d = ST_SWITCH;
            else if (hist_ok) st_d = ST_HOLD;
          end
        end
        ST_SWITCH: begin
          if (req_hold) begin
            st_d = hold_or_free;
          end else if (req_avail) begin
            st_d  = ST_LOCK;
            ref_d = req_ref;
          end else if (auto_en && pick_any) begin
            st_d  = ST_LOCK;
            ref_d = pick_idx;
          end else begin
            st_d = hold_or_free;
          end
          if (st_d == ST_LOCK && ref_d == lost_q) lost_d = '0;
        end
        ST_LOCK: begin
          if (req_chg) begin
            st_d = req_hold ? hold_or_free : ST_SWITCH;
          end else if (!cur_avail || bad_ref) begin
            lost_d = ref_q;
            st_d   = (auto_en && any_other) ? ST_SWITCH : hold_or_free;
          end else if (revert_hit) begin
            lost_d = '0;
            st_d   = ST_SWITCH;
          end
        end
        default: begin
          if (!hist_ok)                    st_d = ST_FREE;
          else if (req_chg && !req_hold)   st_d = ST_SWITCH;
          else if (req_avail)              st_d = ST_SWITCH;
        end
      endcase
    end
    if (st_d == ST_FREE) lost_d = '0;
    if (st_d == ST_FREE || st_d == ST_HOLD) ref_d = '0;
  end

  always_comb begin
    sub_d = sub_q;
    case (st_d)
      ST_FREE:   sub_d = SUB_FREE;
      ST_HOLD:   sub_d = SUB_HOLD;
      ST_SWITCH: sub_d = (st_q == ST_LOCK) ? SUB_PBO : SUB_NONE;
      default: begin
        if (st_q != ST_LOCK) begin
          sub_d = SUB_FACQ;
        end else if (sub_q == SUB_FACQ) begin
          if (freq_done) sub_d = SUB_PACQ;
        end else if (sub_q == SUB_PACQ) begin
          if (phase_done) sub_d = SUB_TRK0;
        end else if (trk_step && sub_q < SUB_TRK3) begin
          sub_d = sub_q + 4'd1;
        end
      end
    endcase
  end

  assign st_ld   = (st_d != st_q);
  assign ref_ld  = (ref_d != ref_q);
  assign lost_ld = (lost_d != lost_q);
  assign sub_ld  = (sub_d != sub_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_FREE;
      ref_q      <= '0;
      lost_q     <= '0;
      sub_q      <= SUB_FREE;
      hist_blk_q <= 1'b0;
    end else begin
      if (st_ld)   st_q   <= st_d;
      if (ref_ld)  ref_q  <= ref_d;
      if (lost_ld) lost_q <= lost_d;
      if (sub_ld)  sub_q  <= sub_d;
      if (hist_clr)         hist_blk_q <= 1'b1;
      else if (!hist_valid) hist_blk_q <= 1'b0;
    end
  end

  assign state_o      = st_q;
  assign ref_o        = ref_q;
  assign sub_o        = sub_q;
  assign ind_holdover = (st_q == ST_HOLD);
  assign ind_freerun  = (st_q == ST_FREE);

  for (genvar g = 0; g < NR; g++) begin : g_ind
    assign ind_ref_lock[g] = (st_q == ST_LOCK) && (ref_q == IW'(g + 1)) &&
                             (sub_q >= SUB_TRK0) && (sub_q <= SUB_TRK3);
  end
  assign ind_unlock = ~|ind_ref_lock;
endmodule

// File: rtl/clkref_mode_chk.sv
module clkref_mode_chk #(
  parameter int NR = clkref_pkg::N_REF,
  parameter int IW = clkref_pkg::IDX_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    pin_code,
  input logic          reg_sel,
  input logic [NR-1:0] ref_valid,
  input logic          hist_valid,
  input logic          hist_clr,
  input logic [1:0]    state_o,
  input logic [IW-1:0] ref_o,
  input logic [3:0]    sub_o,
  input logic [NR-1:0] ind_ref_lock
);
  logic cur_ok;
  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (ref_o == IW'(i + 1)) cur_ok = ref_valid[i];
    end
  end

  assert_free_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && pin_code == 3'b000) |=> (state_o == 2'd0));

  assert_hold_needs_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !hist_valid) |=> (state_o == 2'd0));

  assert_switch_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |=> (state_o != 2'd1));

  assert_lost_ref_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !cur_ok) |=> (state_o != 2'd2));

  assert_no_ref_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 || state_o == 2'd3) |-> (ref_o == '0));

  assert_lock_entry_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> (sub_o == 4'd1));

  assert_single_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ind_ref_lock));

  assert_clear_blocks_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (state_o != 2'd3));
endmodule

bind clkref_mode_ctrl clkref_mode_chk #(.NR(NR), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .reg_sel(reg_sel),
  .ref_valid(ref_valid), .hist_valid(hist_valid), .hist_clr(hist_clr),
  .state_o(state_o), .ref_o(ref_o), .sub_o(sub_o), .ind_ref_lock(ind_ref_lock)
);

// File: tb/sim_clkref_mode_ctrl.sv
`timescale 1ns/100ps
module sim_clkref_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pin_code;
  logic       reg_sel;
  logic [3:0] reg_code;
  logic       auto_en, revert_en, prio_we;
  logic [2:0] prio_sel;
  logic [3:0] prio_val;
  logic [5:0] ref_valid;
  logic       hist_valid, hist_clr, freq_done, phase_done, trk_step, bad_ref;
  logic [1:0] state_o;
  logic [2:0] ref_o;
  logic [3:0] sub_o;
  logic       ind_holdover, ind_freerun, ind_unlock;
  logic [5:0] ind_ref_lock;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkref_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .reg_sel(reg_sel), .reg_code(reg_code),
    .auto_en(auto_en), .revert_en(revert_en), .prio_we(prio_we), .prio_sel(prio_sel),
    .prio_val(prio_val), .ref_valid(ref_valid), .hist_valid(hist_valid), .hist_clr(hist_clr),
    .freq_done(freq_done), .phase_done(phase_done), .trk_step(trk_step), .bad_ref(bad_ref),
    .state_o(state_o), .ref_o(ref_o), .sub_o(sub_o), .ind_holdover(ind_holdover),
    .ind_freerun(ind_freerun), .ind_unlock(ind_unlock), .ind_ref_lock(ind_ref_lock)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_code = 3'b000; reg_sel = 1'b0; reg_code = 4'b0000;
    auto_en = 1'b0; revert_en = 1'b0; prio_we = 1'b0; prio_sel = 3'd0; prio_val = 4'd0;
    ref_valid = 6'b111111; hist_valid = 1'b1; hist_clr = 1'b0;
    freq_done = 1'b0; phase_done = 1'b0; trk_step = 1'b0; bad_ref = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic write_prio(input int r, input int p);
    prio_we = 1'b1; prio_sel = 3'(r); prio_val = 4'(p);
    tick(1);
    prio_we = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset ref", ref_o, 0);
    chk("R1 reset sub", sub_o, 9);
    chk("R11 reset freerun ind", ind_freerun, 1);
  endtask

  task automatic t_pin_decode();
    pin_code = 3'b001; tick(1);
    chk("R3 change from free to switch", state_o, 1);
    chk("R10 switch from free sub", sub_o, 0);
    tick(1);
    chk("R5 lock state", state_o, 2);
    chk("R1 code 001 ref", ref_o, 1);
    pin_code = 3'b111; tick(1);
    chk("R10 build-out sub", sub_o, 7);
    tick(1);
    chk("R1 code 111 ref", ref_o, 6);
    chk("R10 lock entry sub", sub_o, 1);
    chk("R11 unlock during acq", ind_unlock, 1);
  endtask

  task automatic t_substates();
    freq_done = 1'b1; tick(1); freq_done = 1'b0;
    chk("R10 freq acq done", sub_o, 2);
    phase_done = 1'b1; tick(1); phase_done = 1'b0;
    chk("R10 phase acq done", sub_o, 3);
    chk("R11 lock ind ref6", ind_ref_lock, 6'b100000);
    chk("R11 unlock low", ind_unlock, 0);
    for (int k = 0; k < 4; k++) begin
      trk_step = 1'b1; tick(1); trk_step = 1'b0;
      chk("R10 tracking step", sub_o, (k < 3) ? 4 + k : 6);
    end
  endtask

  task automatic t_free_request();
    pin_code = 3'b000; tick(1);
    chk("R3 free request state", state_o, 0);
    chk("R10 free ref zero", ref_o, 0);
    chk("R10 free sub", sub_o, 9);
  endtask

  task automatic t_holdover_gate();
    do_reset();
    hist_valid = 1'b0; pin_code = 3'b011; tick(1);
    chk("R4 hold refused without history", state_o, 0);
    hist_valid = 1'b1; tick(1);
    chk("R4 no retry without change", state_o, 0);
    pin_code = 3'b000; tick(1);
    pin_code = 3'b011; tick(1);
    chk("R4 hold entered", state_o, 3);
    chk("R10 hold sub", sub_o, 8);
    chk("R11 holdover ind", ind_holdover, 1);
    hist_valid = 1'b0; tick(1);
    chk("R4 history lost to free", state_o, 0);
  endtask

  task automatic t_register_code();
    do_reset();
    reg_sel = 1'b1; reg_code = 4'b0001; pin_code = 3'b110; tick(2);
    chk("R2 register code ref", ref_o, 1);
    pin_code = 3'b000; tick(1);
    chk("R2 pins ignored", state_o, 2);
    reg_code = 4'b1110; tick(2);
    chk("R2 bad code keeps state", state_o, 2);
    chk("R2 bad code keeps ref", ref_o, 1);
    reg_code = 4'b0000; tick(1);
    chk("R2 register free", state_o, 0);
  endtask

  task automatic t_auto_priority();
    do_reset();
    auto_en = 1'b1; ref_valid = 6'b001010; pin_code = 3'b001; tick(2);
    chk("R13 default priority pick", ref_o, 2);
    pin_code = 3'b000; tick(1);
    write_prio(4, 7);
    pin_code = 3'b001; tick(2);
    chk("R6 tie to lower ref", ref_o, 2);
    pin_code = 3'b000; tick(1);
    write_prio(4, 9);
    pin_code = 3'b001; tick(2);
    chk("R13 written priority pick", ref_o, 4);
    pin_code = 3'b000; tick(1);
    write_prio(4, 0);
    pin_code = 3'b001; tick(2);
    chk("R6 zero priority excluded", ref_o, 2);
    pin_code = 3'b000; tick(1);
    write_prio(2, 0);
    pin_code = 3'b001; tick(2);
    chk("R6 none available holdover", state_o, 3);
    pin_code = 3'b000; hist_valid = 1'b0; tick(1);
    pin_code = 3'b001; tick(2);
    chk("R6 none available no history", state_o, 0);
  endtask

  task automatic t_manual_holdover();
    do_reset();
    ref_valid = 6'b111110; pin_code = 3'b001; tick(2);
    chk("R7 manual unavailable hold", state_o, 3);
    chk("R10 hold ref zero", ref_o, 0);
    ref_valid = 6'b111111; tick(1);
    chk("R14 reacquire to switch", state_o, 1);
    tick(1);
    chk("R14 reacquire lock ref", ref_o, 1);
  endtask

  task automatic t_lock_loss();
    ref_valid = 6'b111110; tick(1);
    chk("R8 manual loss hold", state_o, 3);
    ref_valid = 6'b111111; tick(2);
    auto_en = 1'b1; ref_valid = 6'b111110; tick(1);
    chk("R8 auto loss switch", state_o, 1);
    tick(1);
    chk("R8 auto substitute", ref_o, 2);
    auto_en = 1'b0; bad_ref = 1'b1; tick(1); bad_ref = 1'b0;
    chk("R8 bad ref hold", state_o, 3);
  endtask

  task automatic t_revertive(input bit rev);
    do_reset();
    auto_en = 1'b1; revert_en = rev; pin_code = 3'b100; tick(2);
    chk("R9 initial ref3", ref_o, 3);
    ref_valid = 6'b111011; tick(2);
    chk("R9 fallback ref1", ref_o, 1);
    ref_valid = 6'b111111; tick(1);
    chk("R9 restore reaction", state_o, rev ? 1 : 2);
    tick(1);
    chk("R9 ref after restore", ref_o, rev ? 3 : 1);
  endtask

  task automatic t_history_clear();
    do_reset();
    hist_clr = 1'b1; tick(1); hist_clr = 1'b0;
    pin_code = 3'b011; tick(1);
    chk("R12 cleared history blocks", state_o, 0);
    hist_valid = 1'b0; tick(1);
    hist_valid = 1'b1; pin_code = 3'b000; tick(1);
    pin_code = 3'b011; tick(1);
    chk("R12 history valid again", state_o, 3);
  endtask

  initial begin
    t_reset_state();
    t_pin_decode();
    t_substates();
    t_free_request();
    t_holdover_gate();
    t_register_code();
    t_auto_priority();
    t_manual_holdover();
    t_lock_loss();
    t_revertive(1'b1);
    t_revertive(1'b0);
    t_history_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule